// File: doc/BRIEF.md
# Chip-Select Sequencer With Programmable Gaps

This block owns the chip-select bus of a serial master. A serializer raises a frame request, and the sequencer asserts the selected chip-select line. It waits a programmed number of serial-clock periods and then grants the frame with a one-cycle pulse. When the serializer reports the last clock edge, the sequencer holds the line for a trailing gap, releases it and enforces a minimum idle time before the next selection. Delays are counted in serial-clock periods: a tick input from the clock divider pulses once per period.

Three selection behaviours are offered. In automatic mode the line is framed around every transfer. In hold mode it stays asserted across frames, and only an inter-frame spacing separates them. In off mode frames are still paced but the line is never driven active. Each line has its own idle level in a default register. The active level is the inverse of that bit, so lines of either polarity can share the bus. The default register implements exactly one bit per line, so writing all ones and reading back shows how many lines exist.

Top module: `cs_sequencer`

## Requirements
- R1: After reset the register readbacks are: select 0, idle levels all ones, mode 0, timing word 0 (address 3) = 0x00010001 and timing word 1 (address 4) = 0x00000001. The bus sits at the idle levels and no grant is issued.
- R2: The register addresses are: 0 line select, 1 idle levels, 2 mode, 3 timing word 0, 4 timing word 1. Reads return only implemented bits, so the idle register returns NUM_CS ones after an all-ones write and the select register returns NUM_CS-1. Timing word 0 carries the lead delay in bits 7:0 and the trail delay in bits 23:16. Timing word 1 carries the rest time in bits 7:0 and the frame spacing in bits 23:16.
- R3: Only the selected line ever leaves its idle level, and when active it takes the inverse of its idle bit.
- R4: In automatic mode (mode 0), with a tick every cycle, the grant pulse comes lead+1 cycles after the line turns active.
- R5: With a tick every cycle, the line returns to idle trail+1 cycles after the cycle in which frame_done is sampled.
- R6: With a request waiting, the next selection comes rest+2 cycles after the line returned to idle.
- R7: In hold mode (mode 2) the line stays active after a frame. With a request waiting, the next grant comes spacing+2 cycles after frame_done is sampled.
- R8: A held line is released within two cycles of a write that changes the mode, the select or the idle register. A write of the same value does not release it.
- R9: In off mode (mode 3) frames are granted but no line leaves its idle level.
- R10: Every grant is a single-cycle pulse.
- R11: Delay counters advance only on cycles with sck_tick high. With no tick the grant is withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the addressed register |
| sck_tick | input | 1 | One pulse per serial-clock period |
| frame_req | input | 1 | Serializer requests a frame |
| frame_done | input | 1 | Serializer reports the last clock edge of the frame |
| frame_go | output | 1 | Grant pulse: the frame may start |
| cs_out | output | NUM_CS | Chip-select bus |

## Verification
Automatic-mode frame pairs are swept over every line and over zero and non-zero lead, trail and rest values. Each edge is measured to the cycle, so an off-by-one in any single gap shows up against the other two. A different idle pattern for each line checks that the active line inverts its own bit and that no neighbour moves. Hold-mode runs separate the spacing gap from the rest gap and show that same-value writes keep the line. Off-mode runs and a stalled tick show that pacing continues without drive and that counters wait for ticks.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

    localparam int DLY_W = 8;
    localparam int REG_W = 32;
    localparam int LO_LSB = 0;
    localparam int HI_LSB = 16;

    localparam logic [2:0] A_SEL  = 3'd0;
    localparam logic [2:0] A_IDLE = 3'd1;
    localparam logic [2:0] A_MODE = 3'd2;
    localparam logic [2:0] A_TIM0 = 3'd3;
    localparam logic [2:0] A_TIM1 = 3'd4;

    localparam logic [1:0] M_AUTO = 2'd0;
    localparam logic [1:0] M_HOLD = 2'd2;
    localparam logic [1:0] M_OFF  = 2'd3;

    typedef struct packed {
        logic [DLY_W-1:0] lead;
        logic [DLY_W-1:0] trail;
        logic [DLY_W-1:0] rest;
        logic [DLY_W-1:0] spacing;
    } gap_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_TAIL,
        ST_GAP,
        ST_SPACE
    } seq_state_t;

    function automatic logic mode_holds(input logic [1:0] m);
        return m == M_HOLD;
    endfunction

    function automatic logic mode_drives(input logic [1:0] m);
        return m != M_OFF;
    endfunction

    function automatic logic [REG_W-1:0] pack_pair(input logic [DLY_W-1:0] lo,
                                                   input logic [DLY_W-1:0] hi);
        logic [REG_W-1:0] w;
        w = '0;
        w[LO_LSB +: DLY_W] = lo;
        w[HI_LSB +: DLY_W] = hi;
        return w;
    endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
    import cs_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [ID_W-1:0]   sel,
    output logic [NUM_CS-1:0] idle,
    output logic [1:0]        mode,
    output gap_cfg_t          gaps,
    output logic              rel_evt
);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel          <= '0;
            idle         <= '1;
            mode         <= M_AUTO;
            gaps.lead    <= DLY_W'(1);
            gaps.trail   <= DLY_W'(1);
            gaps.rest    <= DLY_W'(1);
            gaps.spacing <= '0;
            rel_evt      <= 1'b0;
        end else begin
            rel_evt <= 1'b0;
            if (we) begin
                case (addr)
                    A_SEL: begin
                        if (wdata[ID_W-1:0] != sel) rel_evt <= 1'b1;
                        sel <= wdata[ID_W-1:0];
                    end
                    A_IDLE: begin
                        if (wdata[NUM_CS-1:0] != idle) rel_evt <= 1'b1;
                        idle <= wdata[NUM_CS-1:0];
                    end
                    A_MODE: begin
                        if (wdata[1:0] != mode) rel_evt <= 1'b1;
                        mode <= wdata[1:0];
                    end
                    A_TIM0: begin
                        gaps.lead  <= wdata[LO_LSB +: DLY_W];
                        gaps.trail <= wdata[HI_LSB +: DLY_W];
                    end
                    A_TIM1: begin
                        gaps.rest    <= wdata[LO_LSB +: DLY_W];
                        gaps.spacing <= wdata[HI_LSB +: DLY_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            A_SEL:   rdata = REG_W'(sel);
            A_IDLE:  rdata = REG_W'(idle);
            A_MODE:  rdata = REG_W'(mode);
            A_TIM0:  rdata = pack_pair(gaps.lead, gaps.trail);
            A_TIM1:  rdata = pack_pair(gaps.rest, gaps.spacing);
            default: rdata = '0;
        endcase
    end

    // R8: a release event only follows a register write
    a_r8_release_after_write: assert property (@(posedge clk) disable iff (rst)
        rel_evt |-> $past(we));

endmodule

// File: rtl/cs_gap_cnt.sv
module cs_gap_cnt
    import cs_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);

    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (tick && cnt != '0) cnt <= cnt - DLY_W'(1);
    end

    assign zero = (cnt == '0);

    // R11: without a tick and without a load the count holds
    a_r11_frozen_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt));

    // R11: the count never rises except on a load
    a_r11_counts_down: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> cnt <= $past(cnt));

endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
    import cs_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_req,
    input  logic             frame_done,
    input  logic [1:0]       mode,
    input  gap_cfg_t         gaps,
    input  logic             rel_evt,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [DLY_W-1:0] cnt_val,
    output logic             cs_on,
    output logic             frame_go
);

    seq_state_t state, nxt;
    logic       nxt_on, go_nxt, rel_pend, rel, clr_rel;

    assign rel = rel_pend | rel_evt;

    always_comb begin
        nxt      = state;
        nxt_on   = cs_on;
        cnt_load = 1'b0;
        cnt_val  = '0;
        go_nxt   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cs_on && rel) begin
                    nxt_on   = 1'b0;
                    nxt      = ST_GAP;
                    cnt_load = 1'b1;
                    cnt_val  = gaps.rest;
                end else if (frame_req) begin
                    if (cs_on) begin
                        nxt    = ST_XFER;
                        go_nxt = 1'b1;
                    end else begin
                        nxt_on   = mode_drives(mode);
                        nxt      = ST_SETUP;
                        cnt_load = 1'b1;
                        cnt_val  = gaps.lead;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    nxt    = ST_XFER;
                    go_nxt = 1'b1;
                end
            end
            ST_XFER: begin
                if (frame_done) begin
                    cnt_load = 1'b1;
                    if (mode_holds(mode) && cs_on && !rel) begin
                        nxt     = ST_SPACE;
                        cnt_val = gaps.spacing;
                    end else begin
                        nxt     = ST_TAIL;
                        cnt_val = gaps.trail;
                    end
                end
            end
            ST_TAIL: begin
                if (cnt_zero) begin
                    nxt_on   = 1'b0;
                    nxt      = ST_GAP;
                    cnt_load = 1'b1;
                    cnt_val  = gaps.rest;
                end
            end
            ST_GAP, ST_SPACE: begin
                if (cnt_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign clr_rel = (state == ST_IDLE && nxt == ST_SETUP) || (cs_on && !nxt_on);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cs_on    <= 1'b0;
            frame_go <= 1'b0;
            rel_pend <= 1'b0;
        end else begin
            state    <= nxt;
            cs_on    <= nxt_on;
            frame_go <= go_nxt;
            rel_pend <= rel & ~clr_rel;
        end
    end

    // R10: a grant lasts one cycle
    a_r10_go_single: assert property (@(posedge clk) disable iff (rst)
        frame_go |=> !frame_go);

    // R9: the line is never selected while off mode is programmed
    a_r9_off_never_asserts: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_on) |-> $past(mode) != M_OFF);

    // R8: a line drops only after its trail gap or on a release
    a_r8_drop_reason: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_on) |-> ($past(state) == ST_TAIL) ||
                         ($past(state) == ST_IDLE && ($past(rel_pend) || $past(rel_evt))));

    // R7: the line stays selected through the frame spacing
    a_r7_spacing_keeps_line: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SPACE) |-> cs_on);

endmodule

// File: rtl/cs_drive.sv
module cs_drive
    import cs_seq_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_on,
    input  logic [ID_W-1:0]   sel,
    input  logic [NUM_CS-1:0] idle,
    output logic [NUM_CS-1:0] cs_out
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_out[i] = idle[i] ^ (cs_on && sel == ID_W'(i));
    end

    // R3: at most one line away from its idle level
    a_r3_single_line: assert property (@(posedge clk) disable iff (rst)
        $countones(cs_out ^ idle) <= 1);

    // R3: with nothing selected the bus matches the idle levels
    a_r3_idle_bus: assert property (@(posedge clk) disable iff (rst)
        !cs_on |-> cs_out == idle);

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
    import cs_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              sck_tick,
    input  logic              frame_req,
    input  logic              frame_done,
    output logic              frame_go,
    output logic [NUM_CS-1:0] cs_out
);

    localparam int ID_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    logic [ID_W-1:0]   sel;
    logic [NUM_CS-1:0] idle;
    logic [1:0]        mode;
    gap_cfg_t          gaps;
    logic              rel_evt, cnt_load, cnt_zero, cs_on;
    logic [DLY_W-1:0]  cnt_val;

    cs_cfg_regs #(.NUM_CS(NUM_CS), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .sel(sel), .idle(idle), .mode(mode), .gaps(gaps),
        .rel_evt(rel_evt)
    );

    cs_gap_cnt u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
        .tick(sck_tick), .zero(cnt_zero)
    );

    cs_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .frame_req(frame_req), .frame_done(frame_done),
        .mode(mode), .gaps(gaps), .rel_evt(rel_evt), .cnt_zero(cnt_zero),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .cs_on(cs_on), .frame_go(frame_go)
    );

    cs_drive #(.NUM_CS(NUM_CS), .ID_W(ID_W)) u_drive (
        .clk(clk), .rst(rst), .cs_on(cs_on), .sel(sel), .idle(idle), .cs_out(cs_out)
    );

endmodule

// File: tb/test_cs_sequencer.sv
module test_cs_sequencer;
    localparam int NCS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic           cfg_we = 1'b0;
    logic [2:0]     cfg_addr = 3'd0;
    logic [31:0]    cfg_wdata = 32'd0;
    logic [31:0]    cfg_rdata;
    logic           sck_tick = 1'b1;
    logic           frame_req = 1'b0;
    logic           frame_done = 1'b0;
    logic           frame_go;
    logic [NCS-1:0] cs_out;

    cs_sequencer #(.NUM_CS(NCS)) i_cs_sequencer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sck_tick(sck_tick),
        .frame_req(frame_req), .frame_done(frame_done), .frame_go(frame_go),
        .cs_out(cs_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;
    logic [NCS-1:0] idle_m = '1;
    bit watch_off = 0;
    bit watch_hold = 0;
    int hold_id = 0;
    int off_viol = 0;
    int hold_viol = 0;

    always @(negedge clk) begin
        if (watch_off && cs_out !== idle_m) off_viol++;
        if (watch_hold && cs_out[hold_id] === idle_m[hold_id]) hold_viol++;
    end

    task automatic chk(input string r, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic bit line_act(input int id);
        return cs_out[id] !== idle_m[id];
    endfunction

    task automatic wait_line(input int id, input bit act, output int t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (line_act(id) != act && n < 300);
        if (n >= 300) chk("timeout waiting for line", 0, 1);
        t = cyc;
    endtask

    task automatic wait_go(output int t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (frame_go !== 1'b1 && n < 300);
        if (n >= 300) chk("timeout waiting for grant", 0, 1);
        t = cyc;
    endtask

    task automatic pulse_done(output int t);
        @(negedge clk);
        frame_done = 1'b1;
        t = cyc + 1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic run_auto(input int id, input int a, input int b, input int c);
        int ta, tg, td, tz, tn;
        idle_m = NCS'(4'b0110 ^ id);
        wr(3'd1, 32'(idle_m));
        wr(3'd0, 32'(id));
        wr(3'd3, 32'(a) | (32'(b) << 16));
        wr(3'd4, 32'(c));
        @(negedge clk);
        frame_req = 1'b1;
        wait_line(id, 1'b1, ta);
        chk("R3 only selected line inverted", cs_out, idle_m ^ NCS'(1 << id));
        wait_go(tg);
        frame_req = 1'b0;
        chk("R4 lead delay", tg - ta, a + 1);
        @(negedge clk);
        chk("R10 grant one cycle", frame_go, 0);
        pulse_done(td);
        wait_line(id, 1'b0, tz);
        chk("R5 trail delay", tz - td, b + 1);
        chk("R3 bus idle after frame", cs_out, idle_m);
        frame_req = 1'b1;
        wait_line(id, 1'b1, tn);
        chk("R6 rest time", tn - tz, c + 2);
        wait_go(tg);
        frame_req = 1'b0;
        pulse_done(td);
        wait_line(id, 1'b0, tz);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int t0, t1, t2, ngo;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 bus idle", cs_out, 4'hF);
        chk("R1 no grant", frame_go, 0);
        rd(3'd0, d); chk("R1 select", d, 0);
        rd(3'd1, d); chk("R1 idle levels", d, 32'hF);
        rd(3'd2, d); chk("R1 mode", d, 0);
        rd(3'd3, d); chk("R1 timing word 0", d, 32'h0001_0001);
        rd(3'd4, d); chk("R1 timing word 1", d, 32'h0000_0001);

        // R2 readback and line-count probe
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R2 idle probe", d, 32'hF);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 select width", d, 3);
        wr(3'd3, 32'h1234_5678); rd(3'd3, d); chk("R2 timing word 0 fields", d, 32'h0034_0078);
        wr(3'd4, 32'h8765_4321); rd(3'd4, d); chk("R2 timing word 1 fields", d, 32'h0065_0021);
        wr(3'd2, 32'h0000_0002); rd(3'd2, d); chk("R2 mode field", d, 2);
        wr(3'd2, 32'h0);

        // R3..R6, R10 sweep in automatic mode
        for (int id = 0; id < NCS; id++)
            for (int ai = 0; ai < 2; ai++)
                for (int bi = 0; bi < 2; bi++)
                    for (int ci = 0; ci < 2; ci++)
                        run_auto(id, ai * 2, bi * 3, ci * 2);

        // R7 / R8 hold mode
        idle_m = 4'hF;
        hold_id = 2;
        wr(3'd1, 32'hF);
        wr(3'd0, 32'd2);
        wr(3'd3, 32'h0001_0001);
        wr(3'd4, 32'h0003_0001);
        wr(3'd2, 32'd2);
        @(negedge clk);
        frame_req = 1'b1;
        wait_line(2, 1'b1, t0);
        wait_go(t1);
        watch_hold = 1;
        pulse_done(t0);
        wait_go(t2);
        frame_req = 1'b0;
        chk("R7 frame spacing", t2 - t0, 5);
        pulse_done(t0);
        repeat (8) @(negedge clk);
        chk("R7 line held between frames", hold_viol, 0);
        chk("R7 line still active", line_act(2), 1);
        wr(3'd2, 32'd2);
        repeat (4) @(negedge clk);
        chk("R8 same-value write keeps line", line_act(2), 1);
        chk("R8 no drop on same-value write", hold_viol, 0);
        watch_hold = 0;
        wr(3'd2, 32'd0);
        repeat (2) @(negedge clk);
        chk("R8 changed mode releases line", line_act(2), 0);
        repeat (5) @(negedge clk);

        // R9 off mode
        wr(3'd0, 32'd1);
        wr(3'd2, 32'd3);
        watch_off = 1;
        @(negedge clk);
        frame_req = 1'b1;
        wait_go(t1);
        frame_req = 1'b0;
        chk("R9 grant in off mode", frame_go, 1);
        pulse_done(t0);
        repeat (10) @(negedge clk);
        frame_req = 1'b1;
        wait_go(t1);
        frame_req = 1'b0;
        pulse_done(t0);
        repeat (10) @(negedge clk);
        chk("R9 no line driven in off mode", off_viol, 0);
        watch_off = 0;
        wr(3'd2, 32'd0);

        // R11 tick gating
        wr(3'd3, 32'h0000_0002);
        wr(3'd4, 32'h0000_0001);
        @(negedge clk);
        sck_tick = 1'b0;
        frame_req = 1'b1;
        wait_line(1, 1'b1, t0);
        ngo = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (frame_go === 1'b1) ngo++;
        end
        chk("R11 no grant without ticks", ngo, 0);
        sck_tick = 1'b1;
        wait_go(t1);
        frame_req = 1'b0;
        chk("R11 grant after ticks resume", t1 - t0, 18);
        pulse_done(t0);
        wait_line(1, 1'b0, t2);
        chk("R11 bus idle at end", cs_out, idle_m);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule